// File: doc/BRIEF.md
# Tile Line Pixel Expander

This block turns one line of a 4-bit-per-pixel tile into eight 8-bit framebuffer pixels. The line arrives as a 32-bit word whose nibbles are stored in an interleaved order. It comes with a 16-bit tile map entry:

- the upper four bits of the entry give a palette number;
- the lower twelve bits give a tile address.

Each output pixel byte joins the palette number, in its upper nibble, to the pixel's colour index, in its lower nibble. The eight bytes leave the block as two 32-bit words on consecutive output beats.

A plane-mode bit travels with each request and selects one of two behaviours:

- **Opaque mode** (background layer): every byte is emitted as formed.
- **Transparent mode** (upper layer): any pixel whose colour index is zero becomes the byte 0x00, whatever its palette. A later overwrite stage can then leave the framebuffer pixel untouched.

The tile address and a 3-bit line number ride alongside both output words, for downstream address generation.

Both the input and the output use valid/ready handshakes:

- **Input:** a request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while no line is held, so the block takes at most one line per three cycles when the output never stalls.
- **Output:** `out_valid` rises on the edge that takes a request. A word leaves on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the current word and its side fields hold steady.

Top module: `tile_line_expander`

## Requirements
- R1: When `in_ready` is high, an edge with `in_valid` high takes the request. On that same edge `out_valid` goes high and `out_second` goes low.
- R2: While reset is held, and on the first cycle after it, `out_valid` is low and `in_ready` is high.
- R3: Input nibble slots are counted from the most significant end (bits 31:28 are slot 0). They hold the pixels in the order 4, 0, 5, 1, 6, 2, 7, 3.
- R4: In opaque mode (`in_transparent` = 0), each output byte is {palette[3:0], index[3:0]}, including bytes whose index is zero.
- R5: In transparent mode (`in_transparent` = 1), a pixel with index zero yields 0x00. A pixel with a non-zero index yields {palette, index}.
- R6: The first beat (`out_second` = 0) carries pixels 0..3 and the second beat (`out_second` = 1) carries pixels 4..7. In each word the lower-numbered pixel sits in the more significant byte (pixel 0 or 4 in bits 31:24).
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_word`, `out_second`, `out_tile_addr` and `out_row` stay unchanged.
- R8: `in_ready` stays low from the edge that takes a request until the edge that hands off its second word. Requests presented during that time are ignored.
- R9: `out_tile_addr` equals entry bits 11:0 and `out_row` equals `in_row`. Both hold the same value on the two beats of a line.
- R10: After the second word is handed off, `out_valid` is low and `in_ready` is high on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_entry | input | 16 | Tile map entry: palette in 15:12, tile address in 11:0 |
| in_line | input | 32 | Interleaved tile line, eight 4-bit pixels |
| in_transparent | input | 1 | 1 = transparent plane mode, 0 = opaque |
| in_row | input | 3 | Line number within the tile |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the word on this edge |
| out_word | output | 32 | Four pixel bytes |
| out_second | output | 1 | 0 = pixels 0..3, 1 = pixels 4..7 |
| out_tile_addr | output | 12 | Tile address of the line |
| out_row | output | 3 | Line number of the line |

## Verification
The first word is due one edge after acceptance: it is visible on the cycle after the accepting edge. The second word appears on the cycle after the edge where the first is handed off, and each stalled cycle adds one cycle to that. The bench drives inputs at falling edges and samples outputs at the following falling edge. It tracks the beat count from its own record of which edges had `out_ready` high. Idle state is checked one cycle after the final hand-off.

// File: rtl/tlx_pkg.sv
package tlx_pkg;
  localparam int PIX_W        = 4;
  localparam int PAL_W        = 4;
  localparam int ADDR_W       = 12;
  localparam int ROW_W        = 3;
  localparam int PIX_PER_LINE = 8;
  localparam int PIX_PER_WORD = 4;
  localparam int WORDS        = PIX_PER_LINE / PIX_PER_WORD;
  localparam int BYTE_W       = PAL_W + PIX_W;
  localparam int WORD_W       = PIX_PER_WORD * BYTE_W;
  localparam int LINE_W       = PIX_PER_LINE * PIX_W;
  localparam int ENTRY_W      = PAL_W + ADDR_W;

  typedef enum logic {
    PLANE_OPAQUE      = 1'b0,
    PLANE_TRANSPARENT = 1'b1
  } plane_mode_e;

  typedef struct packed {
    logic [PAL_W-1:0]  pal;
    logic [ADDR_W-1:0] addr;
  } map_entry_t;
endpackage

// File: rtl/tlx_deinterleave.sv
module tlx_deinterleave
  import tlx_pkg::*;
(
  input  logic [LINE_W-1:0]                  line,
  output logic [PIX_PER_LINE-1:0][PIX_W-1:0] pix
);
  // Pixels of the first word take odd slots, pixels of the second word
  // take even slots, counting slots from the top nibble.
  for (genvar i = 0; i < PIX_PER_LINE; i++) begin : g_pix
    localparam int GRP  = i / PIX_PER_WORD;
    localparam int POS  = i % PIX_PER_WORD;
    localparam int SLOT = 2 * POS + ((GRP == 0) ? 1 : 0);
    localparam int LSB  = LINE_W - PIX_W * (SLOT + 1);
    assign pix[i] = line[LSB +: PIX_W];
  end
endmodule

// File: rtl/tlx_pixel_former.sv
module tlx_pixel_former
  import tlx_pkg::*;
(
  input  logic [PAL_W-1:0]  pal,
  input  logic [PIX_W-1:0]  idx,
  input  plane_mode_e       mode,
  output logic [BYTE_W-1:0] pix_byte
);
  logic clear;
  assign clear = (mode == PLANE_TRANSPARENT) && (idx == '0);

  always_comb begin
    if (clear) pix_byte = '0;
    else       pix_byte = {pal, idx};
  end
endmodule

// File: rtl/tlx_beat_sequencer.sv
module tlx_beat_sequencer
  import tlx_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [WORDS-1:0][WORD_W-1:0] load_words,
  input  logic [ADDR_W-1:0]           load_addr,
  input  logic [ROW_W-1:0]            load_row,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [WORD_W-1:0]           out_word,
  output logic                        out_second,
  output logic [ADDR_W-1:0]           out_tile_addr,
  output logic [ROW_W-1:0]            out_row
);
  logic                         busy_q;
  logic                         second_q;
  logic [WORDS-1:0][WORD_W-1:0] words_q;
  logic [ADDR_W-1:0]            addr_q;
  logic [ROW_W-1:0]             row_q;
  logic                         take;
  logic                         hand;

  assign in_ready = !busy_q;
  assign take     = in_valid && in_ready;
  assign hand     = busy_q && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      second_q <= 1'b0;
    end else if (take) begin
      busy_q   <= 1'b1;
      second_q <= 1'b0;
    end else if (hand) begin
      if (second_q) begin
        busy_q   <= 1'b0;
        second_q <= 1'b0;
      end else begin
        second_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      words_q <= load_words;
      addr_q  <= load_addr;
      row_q   <= load_row;
    end
  end

  assign out_valid     = busy_q;
  assign out_second    = second_q;
  assign out_word      = second_q ? words_q[1] : words_q[0];
  assign out_tile_addr = addr_q;
  assign out_row       = row_q;

  a_r1_accept_starts_first: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid && !out_second));

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) &&
      $stable(out_second) && $stable(out_tile_addr) && $stable(out_row)));

  a_r8_no_ready_while_busy: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  a_r6_second_follows_first: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_second) |=> (out_valid && out_second));

  a_r9_side_fields_steady: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_second) |=>
      ($stable(out_tile_addr) && $stable(out_row)));

  a_r10_idle_after_second: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_second) |=> (!out_valid && in_ready));
endmodule

// File: rtl/tile_line_expander.sv
module tile_line_expander
  import tlx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [15:0]        in_entry,
  input  logic [31:0]        in_line,
  input  logic               in_transparent,
  input  logic [2:0]         in_row,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [31:0]        out_word,
  output logic               out_second,
  output logic [11:0]        out_tile_addr,
  output logic [2:0]         out_row
);
  map_entry_t                        entry;
  plane_mode_e                       mode;
  logic [PIX_PER_LINE-1:0][PIX_W-1:0] pix;
  logic [PIX_PER_LINE-1:0][BYTE_W-1:0] bytes;
  logic [WORDS-1:0][WORD_W-1:0]        words;

  assign entry = map_entry_t'(in_entry);
  assign mode  = plane_mode_e'(in_transparent);

  tlx_deinterleave u_deint (
    .line (in_line),
    .pix  (pix)
  );

  for (genvar i = 0; i < PIX_PER_LINE; i++) begin : g_form
    tlx_pixel_former u_form (
      .pal      (entry.pal),
      .idx      (pix[i]),
      .mode     (mode),
      .pix_byte (bytes[i])
    );
  end

  // Lower-numbered pixel lands in the more significant byte of its word.
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar p = 0; p < PIX_PER_WORD; p++) begin : g_byte
      assign words[w][(PIX_PER_WORD-1-p)*BYTE_W +: BYTE_W] =
        bytes[w*PIX_PER_WORD + p];
    end
  end

  tlx_beat_sequencer u_seq (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .load_words    (words),
    .load_addr     (entry.addr),
    .load_row      (in_row),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_word      (out_word),
    .out_second    (out_second),
    .out_tile_addr (out_tile_addr),
    .out_row       (out_row)
  );
endmodule

// File: tb/tile_line_expander_test.sv
module tile_line_expander_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_entry = '0;
  logic [31:0] in_line = '0;
  logic        in_transparent = 1'b0;
  logic [2:0]  in_row = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_word;
  logic        out_second;
  logic [11:0] out_tile_addr;
  logic [2:0]  out_row;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_line_expander uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_entry(in_entry), .in_line(in_line), .in_transparent(in_transparent),
    .in_row(in_row), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .out_second(out_second),
    .out_tile_addr(out_tile_addr), .out_row(out_row)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R3: slot k counted from the top nibble; slots hold pixels 4,0,5,1,6,2,7,3.
  function automatic logic [3:0] pix_of(input logic [31:0] line, input int p);
    int slot = (p < 4) ? (2*p + 1) : (2*(p-4));
    return line[28 - 4*slot +: 4];
  endfunction

  // R4/R5/R6: expected word for a beat.
  function automatic logic [31:0] exp_word(input logic [15:0] entry,
      input logic [31:0] line, input bit transp, input int beat);
    logic [31:0] w = '0;
    for (int p = 0; p < 4; p++) begin
      logic [3:0] idx = pix_of(line, beat*4 + p);
      logic [7:0] b = (transp && idx == 4'h0) ? 8'h00 : {entry[15:12], idx};
      w[24 - 8*p +: 8] = b;
    end
    return w;
  endfunction

  task automatic run_line(input logic [15:0] entry, input logic [31:0] line,
                          input bit transp, input logic [2:0] row,
                          input int stall_pct);
    int beat = 0;
    @(negedge clk);
    check("R1 in_ready before request", {31'b0, in_ready}, 32'd1);
    in_valid = 1'b1; in_entry = entry; in_line = line;
    in_transparent = transp; in_row = row;
    out_ready = 1'b0;
    @(posedge clk);
    while (beat < 2) begin
      @(negedge clk);
      // R8: junk requests while busy must be ignored.
      in_valid = 1'b1;
      in_entry = 16'($urandom); in_line = $urandom;
      in_transparent = 1'($urandom); in_row = 3'($urandom);
      out_ready = (($urandom % 100) >= stall_pct);
      check("R1/R7 out_valid", {31'b0, out_valid}, 32'd1);
      check("R6 out_second", {31'b0, out_second}, beat);
      check(transp ? "R5 word" : "R4 word", out_word,
            exp_word(entry, line, transp, beat));
      check("R8 in_ready low", {31'b0, in_ready}, 32'd0);
      check("R9 tile addr", {20'b0, out_tile_addr}, {20'b0, entry[11:0]});
      check("R9 row", {29'b0, out_row}, {29'b0, row});
      @(posedge clk);
      if (out_ready) beat++;
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
    check("R10 out_valid low", {31'b0, out_valid}, 32'd0);
    check("R10 in_ready high", {31'b0, in_ready}, 32'd1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 out_valid in reset", {31'b0, out_valid}, 32'd0);
    check("R2 in_ready in reset", {31'b0, in_ready}, 32'd1);
    rst = 1'b0;
    @(negedge clk);
    check("R2 out_valid after reset", {31'b0, out_valid}, 32'd0);
    check("R2 in_ready after reset", {31'b0, in_ready}, 32'd1);

    // Directed: R3 order, R4 opaque keeps palette with zero index.
    check("R3 slot 0 is pixel 4", {28'b0, pix_of(32'h40516273, 4)}, 32'd4);
    run_line(16'hA123, 32'h40516273, 1'b0, 3'd5, 0);
    run_line(16'h7FFF, 32'h00000000, 1'b0, 3'd0, 0);
    // R5: transparent, zeros cleared regardless of palette.
    run_line(16'h3ABC, 32'h40506070, 1'b1, 3'd7, 0);
    run_line(16'hF001, 32'h00000000, 1'b1, 3'd1, 0);
    run_line(16'h0555, 32'h0F0F0F0F, 1'b1, 3'd2, 50);
    // R7: heavy stalls.
    run_line(16'hC0DE, 32'h89ABCDEF, 1'b0, 3'd3, 80);

    for (int n = 0; n < 60; n++)
      run_line(16'($urandom), $urandom, 1'($urandom), 3'($urandom),
               int'($urandom % 60));

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule